// File: doc/BRIEF.md
# Masked Pattern-Triggered Capture Buffer

This block watches a stream of 84-bit words arriving from a link decoder and records a window of them into a 512-entry on-chip buffer. Software first loads an 84-bit trigger pattern and a compare mask, then arms the block with a self-clearing command bit. While armed, every valid incoming word is compared with the pattern. Any byte lane, and the top 4-bit field, can be left out of that comparison. The first word that matches is stored at entry 0. Every valid word after it is stored at the next entry until the last entry has been written. The block then stops and reports that the buffer is full.

The same 32-bit register bus that holds the pattern, mask, command and status registers also reaches the buffer. Each entry occupies four consecutive bus addresses. The buffer can be written from the bus as well as read, so software can preload it or overwrite it. Arming again restarts capture at entry 0 and leaves the stored contents in place until new words overwrite them.

Top module: `cap_trig_buffer`

## Requirements
- R1: A bus write to address 0x000 with bit 0 set arms the block on the next clock. Arming sets the write position to entry 0 and clears the full flag, and it works from any state, including during a capture. Address 0x000 always reads as zero.
- R2: While armed, a word is stored only when rx_valid is high and the word matches the pattern under the mask. That matching word goes to entry 0 and capture begins. Non-matching words, and any word with rx_valid low, are not stored and leave the block armed.
- R3: While capturing, each word with rx_valid high goes to the next entry and words with rx_valid low are skipped. After entry 511 is written the block goes idle and sets full, and later words are not stored.
- R4: The mask register is at address 0x002. For k from 0 to 9, mask bit k set excludes pattern bits 8k+7..8k from the compare. Bit 10 set excludes bits 83..80. Bits 31..11 read as zero.
- R5: The pattern is written and read at 0x004 (bits 31..0), 0x005 (bits 63..32) and 0x006 (bits 83..64 in bits 19..0). Bits 31..20 of 0x006 read as zero. The pattern and the mask reset to zero.
- R6: A buffer address has bit 11 set. Bits 10..2 select the entry and bits 1..0 select the lane. Lane 0 holds bits 31..0, lane 1 holds bits 63..32, lane 2 holds bits 83..64 in bits 19..0 with bits 31..20 reading zero, and lane 3 always reads zero and ignores writes.
- R7: A bus write to lane 0, 1 or 2 of an entry changes that part of the entry. Buffer contents are kept across arming.
- R8: The status register at 0x001 has bit 0 = armed, bit 1 = capturing and bit 2 = full. At most one of these bits is set at a time, and all three are zero after reset.
- R9: Read data appears on bus_rdata with bus_rvalid high two clocks after the clock that samples bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for link and bus |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Qualifies rx_word this cycle |
| rx_word | input | 84 | Incoming link word |
| bus_addr | input | 12 | Register/buffer word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |

## Verification
A link word is stored at the rising edge that samples it, so the triggering word lands in entry 0 with no delay. An arm write takes effect at the edge that samples the write. Status and buffer contents are only seen through the bus. A read returns data two clocks after the edge that samples the strobe. The bench drives all inputs on the falling edge and moves a reference model forward at the same time. It then samples bus_rdata on the falling edge two cycles after asserting bus_rd, by which point every state change caused by earlier stimulus has settled.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ARMED = 2'd1,
    CS_CAPT  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/cap_match.sv
module cap_match #(
  parameter int WORD_W = 84,
  localparam int GRP_N = (WORD_W + 7) / 8
) (
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] pattern,
  input  logic [GRP_N-1:0]  mask,
  output logic              hit
);
  logic [GRP_N-1:0] grp_ok;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    localparam int GW = ((WORD_W - 8 * g) < 8) ? (WORD_W - 8 * g) : 8;
    assign grp_ok[g] = mask[g] || (word[8*g +: GW] == pattern[8*g +: GW]);
  end

  assign hit = &grp_ok;
endmodule

// File: rtl/cap_lane_ram.sv
module cap_lane_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_din,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_din,
  output logic [W-1:0]  b_dout
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_din;
    if (a_we) mem[a_addr] <= a_din;
    b_dout <= mem[b_addr];
  end
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
  import cap_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          rx_valid,
  input  logic          match,
  output cap_state_e    st,
  output logic [AW-1:0] ptr,
  output logic          full,
  output logic          cap_we
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  assign cap_we = rx_valid && !arm &&
                  (((st == CS_ARMED) && match) || (st == CS_CAPT));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= CS_IDLE;
      ptr  <= '0;
      full <= 1'b0;
    end else if (arm) begin
      st   <= CS_ARMED;
      ptr  <= '0;
      full <= 1'b0;
    end else if (cap_we) begin
      if (ptr == LAST) begin
        st   <= CS_IDLE;
        ptr  <= '0;
        full <= 1'b1;
      end else begin
        st  <= CS_CAPT;
        ptr <= ptr + 1'b1;
      end
    end
  end

  AST_ARM_ENTERS: assert property (@(posedge clk) disable iff (rst)
    arm |=> (st == CS_ARMED && !full && ptr == '0)); // R1
  AST_PTR_HOME: assert property (@(posedge clk) disable iff (rst)
    (st == CS_ARMED) |-> (ptr == '0)); // R2
  AST_TRIGGER_LEAVES: assert property (@(posedge clk) disable iff (rst)
    (st == CS_ARMED && rx_valid && match && !arm) |=> (st != CS_ARMED)); // R2
  AST_FULL_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    full |-> (st == CS_IDLE)); // R3
  AST_LAST_FILLS: assert property (@(posedge clk) disable iff (rst)
    (cap_we && ptr == LAST) |=> full); // R3
endmodule

// File: rtl/cap_regs.sv
module cap_regs #(
  parameter int WORD_W = 84,
  parameter int DEPTH  = 512,
  localparam int AW     = $clog2(DEPTH),
  localparam int ADDR_W = AW + 3,
  localparam int NLANE  = (WORD_W + 31) / 32,
  localparam int GRP_N  = (WORD_W + 7) / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic               st_armed,
  input  logic               st_capt,
  input  logic               st_full,
  input  logic [NLANE*32-1:0] lane_q,
  output logic               arm_pulse,
  output logic [WORD_W-1:0]  pattern,
  output logic [GRP_N-1:0]   mask,
  output logic [NLANE-1:0]   buf_we,
  output logic [AW-1:0]      buf_entry
);
  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_MASK = 3'd2;
  localparam logic [2:0] OFS_PAT0 = 3'd4;

  logic       is_buf, reg_hit;
  logic [1:0] lane;
  logic [2:0] ofs;
  logic [31:0] reg_val;

  assign is_buf    = bus_addr[ADDR_W-1];
  assign reg_hit   = !is_buf && (bus_addr[ADDR_W-2:3] == '0);
  assign ofs       = bus_addr[2:0];
  assign lane      = bus_addr[1:0];
  assign buf_entry = bus_addr[AW+1:2];
  assign arm_pulse = bus_wr && reg_hit && (ofs == OFS_CMD) && bus_wdata[0];

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    localparam int LW = (k == NLANE - 1) ? (WORD_W - 32 * k) : 32;
    assign buf_we[k] = bus_wr && is_buf && (lane == 2'(k));

    always_ff @(posedge clk) begin
      if (rst) pattern[32*k +: LW] <= '0;
      else if (bus_wr && reg_hit && ofs == OFS_PAT0 + 3'(k))
        pattern[32*k +: LW] <= bus_wdata[LW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mask <= '0;
    else if (bus_wr && reg_hit && ofs == OFS_MASK) mask <= bus_wdata[GRP_N-1:0];
  end

  always_comb begin
    reg_val = '0;
    if (reg_hit) begin
      if (ofs == OFS_STAT) reg_val = {29'd0, st_full, st_capt, st_armed};
      if (ofs == OFS_MASK) reg_val = 32'(mask);
      for (int k = 0; k < NLANE; k++) begin
        if (ofs == OFS_PAT0 + 3'(k))
          reg_val = 32'(pattern >> (32 * k)) &
                    ((k == NLANE - 1) ? ((32'd1 << (WORD_W - 32 * k)) - 32'd1) : 32'hFFFF_FFFF);
      end
    end
  end

  logic        rv1, sel_buf1;
  logic [1:0]  lane1;
  logic [31:0] regv1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv1        <= 1'b0;
      sel_buf1   <= 1'b0;
      lane1      <= '0;
      regv1      <= '0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      rv1        <= bus_rd;
      sel_buf1   <= is_buf;
      lane1      <= lane;
      regv1      <= reg_val;
      bus_rvalid <= rv1;
      if (rv1) begin
        if (!sel_buf1) bus_rdata <= regv1;
        else if (int'(lane1) < NLANE) bus_rdata <= lane_q[32*lane1 +: 32];
        else bus_rdata <= '0;
      end
    end
  end

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_armed, st_capt, st_full})); // R8
endmodule

// File: rtl/cap_trig_buffer.sv
module cap_trig_buffer
  import cap_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int WORD_W = 84,
  localparam int AW     = $clog2(DEPTH),
  localparam int ADDR_W = AW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int NLANE = (WORD_W + 31) / 32;
  localparam int GRP_N = (WORD_W + 7) / 8;

  logic [WORD_W-1:0]   pattern;
  logic [GRP_N-1:0]    mask;
  logic                arm, hit, full, cap_we;
  logic [AW-1:0]       ptr, buf_entry;
  logic [NLANE-1:0]    buf_we;
  logic [NLANE*32-1:0] lane_q;
  cap_state_e          st;

  cap_match #(.WORD_W(WORD_W)) u_match (
    .word(rx_word), .pattern(pattern), .mask(mask), .hit(hit)
  );

  cap_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst(rst), .arm(arm), .rx_valid(rx_valid), .match(hit),
    .st(st), .ptr(ptr), .full(full), .cap_we(cap_we)
  );

  cap_regs #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .st_armed(st == CS_ARMED), .st_capt(st == CS_CAPT), .st_full(full),
    .lane_q(lane_q), .arm_pulse(arm), .pattern(pattern), .mask(mask),
    .buf_we(buf_we), .buf_entry(buf_entry)
  );

  for (genvar k = 0; k < NLANE; k++) begin : g_ram
    localparam int LW = (k == NLANE - 1) ? (WORD_W - 32 * k) : 32;
    logic [LW-1:0] q;

    cap_lane_ram #(.W(LW), .DEPTH(DEPTH)) u_ram (
      .clk(clk),
      .a_we(cap_we), .a_addr(ptr), .a_din(rx_word[32*k +: LW]),
      .b_we(buf_we[k]), .b_addr(buf_entry), .b_din(bus_wdata[LW-1:0]),
      .b_dout(q)
    );
    assign lane_q[32*k +: 32] = 32'(q);
  end
endmodule

// File: tb/cap_trig_buffer_tb_top.sv
module cap_trig_buffer_tb_top;
  localparam int DEPTH = 512;
  localparam int WW    = 84;

  logic        clk = 1'b0, rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [83:0] rx_word = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  cap_trig_buffer dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [83:0] m_mem [DEPTH];
  bit          m_ok [DEPTH];
  int          m_st = 0, m_ptr = 0;
  bit          m_full = 0;
  logic [83:0] m_pat = '0;
  logic [10:0] m_mask = '0;

  function automatic bit f_match(logic [83:0] w);
    logic [83:0] care;
    for (int i = 0; i < 84; i++) care[i] = !m_mask[i/8];
    return ((w ^ m_pat) & care) == '0;
  endfunction

  function automatic logic [31:0] f_status();
    return {29'd0, m_full, m_st == 2, m_st == 1};
  endfunction

  function automatic logic [83:0] f_rand84();
    logic [95:0] t = {$urandom(), $urandom(), $urandom()};
    return t[83:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic bwrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    rx_valid = 0; bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bread(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rx_valid = 0; bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    @(negedge clk);
    if (!bus_rvalid) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 actual=rvalid 0 expected=rvalid 1");
    end
    d = bus_rdata;
  endtask

  task automatic rchk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] d;
    bread(a, d);
    chk(req, d, exp);
  endtask

  task automatic arm();
    bwrite(12'h000, 32'h1);
    m_st = 1; m_ptr = 0; m_full = 0;
  endtask

  task automatic set_mask(logic [10:0] m);
    bwrite(12'h002, 32'(m)); m_mask = m;
  endtask

  task automatic set_pat(logic [83:0] p);
    bwrite(12'h004, p[31:0]);
    bwrite(12'h005, p[63:32]);
    bwrite(12'h006, {12'd0, p[83:64]});
    m_pat = p;
  endtask

  task automatic link(bit v, logic [83:0] w);
    @(negedge clk);
    rx_valid = v; rx_word = w;
    if (v && ((m_st == 1 && f_match(w)) || m_st == 2)) begin
      m_mem[m_ptr] = w; m_ok[m_ptr] = 1;
      if (m_ptr == DEPTH - 1) begin m_st = 0; m_full = 1; m_ptr = 0; end
      else begin m_st = 2; m_ptr++; end
    end
  endtask

  task automatic check_entry(string req, int e);
    logic [11:0] base = {1'b1, 9'(e), 2'b00};
    if (m_ok[e]) begin
      rchk(req, base,         m_mem[e][31:0]);
      rchk(req, base + 12'd1, m_mem[e][63:32]);
      rchk(req, base + 12'd2, {12'd0, m_mem[e][83:64]});
      rchk(req, base + 12'd3, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [83:0] p, w;
    logic [31:0] seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < DEPTH; i++) m_ok[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    // reset state
    rchk("R8 reset status", 12'h001, 32'd0);
    rchk("R4 reset mask", 12'h002, 32'd0);
    rchk("R5 reset pattern lo", 12'h004, 32'd0);
    rchk("R5 reset pattern hi", 12'h006, 32'd0);
    rchk("R1 cmd reads zero", 12'h000, 32'd0);

    // register widths
    bwrite(12'h002, 32'hFFFF_FFFF);
    rchk("R4 mask upper bits zero", 12'h002, 32'h0000_07FF);
    bwrite(12'h006, 32'hFFFF_FFFF);
    rchk("R5 pattern top field width", 12'h006, 32'h000F_FFFF);
    bwrite(12'h005, 32'h1234_5678);
    rchk("R5 pattern mid", 12'h005, 32'h1234_5678);
    set_mask(11'd0);

    // bus access to buffer, lane 3 ignores writes
    bwrite(12'h800, 32'hA5A5_0001);
    bwrite(12'h801, 32'h5A5A_0002);
    bwrite(12'h802, 32'hFFFF_FFFF);
    bwrite(12'h803, 32'hDEAD_BEEF);
    m_mem[0] = {20'hFFFFF, 32'h5A5A_0002, 32'hA5A5_0001}; m_ok[0] = 1;
    check_entry("R6 R7 bus written entry", 0);
    bwrite(12'hFFD, 32'h0BAD_F00D);   // entry 511 lane 1
    m_mem[511] = {20'd0, 32'h0BAD_F00D, 32'd0}; m_ok[511] = 1;
    bwrite(12'hFFC, 32'd0); bwrite(12'hFFE, 32'd0);
    check_entry("R6 R7 last entry", 511);

    // armed, no trigger
    p = f_rand84();
    set_pat(p);
    arm();
    rchk("R1 R8 status armed", 12'h001, 32'h1);
    rchk("R1 cmd self clears", 12'h000, 32'd0);
    for (int i = 0; i < 20; i++) link(1, f_rand84());
    link(0, p);
    rchk("R2 still armed after misses", 12'h001, f_status());
    check_entry("R2 entry0 untouched", 0);

    // trigger and capture to full
    link(1, p);
    for (int i = 0; i < 10; i++) link(1, f_rand84());
    rchk("R8 status capturing", 12'h001, f_status());
    for (int i = 0; i < 700; i++) link(($urandom() % 4) != 0, f_rand84());
    rchk("R3 status full", 12'h001, 32'h4);
    chk("R3 model full", 32'(m_full), 32'd1);
    for (int e = 0; e < DEPTH; e++) check_entry("R3 captured entry", e);

    // masked compare, including top 4-bit field
    p = f_rand84();
    set_pat(p);
    set_mask(11'b100_0000_0101);
    arm();
    rchk("R1 re-arm clears full", 12'h001, 32'h1);
    check_entry("R7 data kept across arm", 5);
    w = p; w[79] = ~w[79];
    link(1, w);                        // byte 9 compared: miss
    rchk("R4 bit79 still compared", 12'h001, 32'h1);
    w = p; w[83:80] = ~w[83:80]; w[7:0] = ~w[7:0]; w[23:16] = ~w[23:16];
    link(1, w);                        // masked lanes only differ: hit
    for (int i = 0; i < 30; i++) link(1, f_rand84());
    rchk("R2 R4 masked trigger capturing", 12'h001, 32'h2);
    for (int e = 0; e < 32; e++) check_entry("R2 R4 masked capture", e);

    // re-arm during capture
    arm();
    rchk("R1 arm during capture", 12'h001, 32'h1);

    // random rounds
    for (int r = 0; r < 4; r++) begin
      set_mask(11'($urandom()));
      p = f_rand84();
      set_pat(p);
      arm();
      for (int i = 0; i < 120; i++) begin
        w = f_rand84();
        if (($urandom() % 16) == 0) w = (w & ~{84{1'b1}}) | p;
        link(($urandom() % 3) != 0, w);
      end
      rchk("R2 R3 random status", 12'h001, f_status());
      for (int e = 0; e < 48; e++) check_entry("R2 R3 random entry", e);
    end

    report();
  end
endmodule